// File: doc/BRIEF.md
# Cycle-Stealing DMA Engine

This block is one DMA channel that copies a block of data from one memory region to another over a shared bus. Software writes a source address, a destination address, a unit count and a unit size through a small register port, then sets the enable bit. From then on the channel makes its own transfer requests. No external trigger is involved.

Each unit moves in two bus cycles. The first reads the unit from the source address and the second writes it to the destination address. The channel asks an arbiter for the bus before each unit and hands the bus back after the write. Other masters can therefore take the bus between any two units. When the remaining count reaches half of the programmed count the channel raises a half-way interrupt. When the count reaches zero it raises a completion interrupt and stops requesting the bus.

Top module: `cs_dma_engine`

## Requirements
- R1: After reset, bus_req, bus_cmd, irq_done and irq_half are low, and all four registers read as zero.
- R2: The register offsets are as follows.
  - Offset 0 holds the source address and offset 1 the destination address.
  - Offset 2 holds the count, which is the low 16 bits of the data.
  - Offset 3 is control:
    - bit 0 is enable/active;
    - bits 2:1 are the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes;
    - bit 3 is done;
    - bit 4 is half.
  - Address and count registers read back the working values.
- R3: Each unit is one read of unit size at the source address. It is followed, in the next cycle after the read is acknowledged, by one write of the same data to the destination address. A command holds its address until it is acknowledged.
- R4: After each unit, the source and destination addresses each advance by the unit size in bytes and the count drops by one.
- R5: In the cycle after a write is acknowledged, bus_req is low. The bus is then requested again for the next unit.
- R6: bus_cmd is never high while bus_gnt is low.
- R7: After the last unit, the channel clears enable and sets done, and irq_done follows done. While done is set, bus_req stays low.
- R8: The half flag and irq_half set on the unit after which the remaining count equals the programmed count shifted right by one.
- R9: A write to control with bit 3 set clears done and half.
- R10: Starting with a count of zero sets done on the next cycle. It makes no bus request.
- R11: While the channel is active, writes to source, destination, count and size have no effect on the transfer.
- R12: A control write that sets enable with a nonzero count raises bus_req on the next cycle, with no other trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_cmd | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Unit size code of the access |
| bus_wdata | output | 128 | Write data, unit in the low bytes |
| bus_rdata | input | 128 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| irq_done | output | 1 | Completion interrupt |
| irq_half | output | 1 | Half-way interrupt |

## Verification
The following bus rules are checked on every cycle:
- no command without a grant;
- a write always directly after an acknowledged read;
- a command address held until acknowledged;
- the bus released in the cycle after each write;
- no request while done is set.

Only the bench scenarios can show the rest. These include the data and the addresses of every unit under each unit size and several grant latencies, and the point at which the half flag rises. They also include the final register values, the clearing of the flags, the zero-count start, and the fact that register writes made during a transfer are ignored.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
    localparam int MAX_UNIT_BYTES = 16;
    localparam int BUS_DATA_W     = 8 * MAX_UNIT_BYTES;

    localparam logic [1:0] REG_SRC = 2'd0;
    localparam logic [1:0] REG_DST = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;
    localparam logic [1:0] REG_CTL = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_SZ   = 1;
    localparam int CTL_DONE = 3;
    localparam int CTL_HALF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_READ,
        ST_WRITE,
        ST_YIELD
    } mv_st_e;

    function automatic logic [4:0] unit_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    unit_bytes = 5'd1;
            2'd1:    unit_bytes = 5'd2;
            2'd2:    unit_bytes = 5'd4;
            default: unit_bytes = 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/cs_dma_regport.sv
module cs_dma_regport
    import cs_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [1:0]        cur_size,
    input  logic              cur_done,
    input  logic              cur_half,
    output logic              ld_src,
    output logic              ld_dst,
    output logic              ld_cnt,
    output logic              ld_size,
    output logic              start,
    output logic              clr_flags,
    output logic [ADDR_W-1:0] reg_rdata
);
    logic ctl_wr;

    always_comb begin
        ctl_wr    = reg_wr && (reg_addr == REG_CTL);
        // R11: programming writes are locked out while the channel runs
        ld_src    = reg_wr && (reg_addr == REG_SRC) && !busy;
        ld_dst    = reg_wr && (reg_addr == REG_DST) && !busy;
        ld_cnt    = reg_wr && (reg_addr == REG_CNT) && !busy;
        ld_size   = ctl_wr && !busy;
        start     = ctl_wr && !busy && reg_wdata[CTL_EN];
        clr_flags = ctl_wr && reg_wdata[CTL_DONE];

        reg_rdata = '0;
        unique case (reg_addr)
            REG_SRC: reg_rdata = cur_src;
            REG_DST: reg_rdata = cur_dst;
            REG_CNT: reg_rdata = {{(ADDR_W-CNT_W){1'b0}}, cur_cnt};
            default: begin
                reg_rdata[CTL_EN]            = busy;
                reg_rdata[CTL_SZ +: 2]       = cur_size;
                reg_rdata[CTL_DONE]          = cur_done;
                reg_rdata[CTL_HALF]          = cur_half;
            end
        endcase
    end
endmodule

// File: rtl/cs_dma_mover.sv
module cs_dma_mover
    import cs_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_src,
    input  logic                  ld_dst,
    input  logic                  ld_cnt,
    input  logic                  ld_size,
    input  logic                  start,
    input  logic                  clr_flags,
    input  logic [ADDR_W-1:0]     wr_data,
    input  logic                  bus_gnt,
    input  logic                  bus_ack,
    input  logic [BUS_DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0]     src_o,
    output logic [ADDR_W-1:0]     dst_o,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [1:0]            size_o,
    output logic                  busy,
    output logic                  done,
    output logic                  half,
    output logic                  bus_req,
    output logic                  bus_cmd,
    output logic                  bus_we,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [1:0]            bus_size,
    output logic [BUS_DATA_W-1:0] bus_wdata
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        mv_st_e                st;
        logic [ADDR_W-1:0]     src;
        logic [ADDR_W-1:0]     dst;
        logic [CNT_W-1:0]      cnt;
        logic [CNT_W-1:0]      mark;
        logic [1:0]            size;
        logic [BUS_DATA_W-1:0] hold;
        logic                  done;
        logic                  half;
    } mv_t;

    mv_t q, d;
    logic [ADDR_W-1:0] step;
    logic [CNT_W-1:0]  left;

    always_comb begin
        d    = q;
        step = ADDR_W'(unit_bytes(q.size));
        left = q.cnt - CNT_ONE;

        if (ld_src)  d.src  = wr_data;
        if (ld_dst)  d.dst  = wr_data;
        if (ld_cnt)  d.cnt  = wr_data[CNT_W-1:0];
        if (ld_size) d.size = wr_data[CTL_SZ +: 2];
        if (clr_flags) begin
            d.done = 1'b0;
            d.half = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.half = 1'b0;
                    if (q.cnt == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.done = 1'b0;
                        d.mark = q.cnt >> 1;
                        d.st   = ST_ASK;
                    end
                end
            end
            ST_ASK: begin
                if (bus_gnt) d.st = ST_READ;
            end
            ST_READ: begin
                if (bus_ack) begin
                    d.hold = bus_rdata;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (bus_ack) begin
                    d.src = q.src + step;
                    d.dst = q.dst + step;
                    d.cnt = left;
                    if (left == q.mark) d.half = 1'b1;
                    if (left == '0) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st   = ST_YIELD;
                    end
                end
            end
            default: d.st = ST_ASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        src_o     = q.src;
        dst_o     = q.dst;
        cnt_o     = q.cnt;
        size_o    = q.size;
        busy      = (q.st != ST_IDLE);
        done      = q.done;
        half      = q.half;
        bus_req   = (q.st == ST_ASK) || (q.st == ST_READ) || (q.st == ST_WRITE);
        bus_cmd   = (q.st == ST_READ) || (q.st == ST_WRITE);
        bus_we    = (q.st == ST_WRITE);
        bus_addr  = (q.st == ST_WRITE) ? q.dst : q.src;
        bus_size  = q.size;
        bus_wdata = q.hold;
    end
endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
    import cs_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [ADDR_W-1:0]     reg_wdata,
    output logic [ADDR_W-1:0]     reg_rdata,
    output logic                  bus_req,
    input  logic                  bus_gnt,
    output logic                  bus_cmd,
    output logic                  bus_we,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [1:0]            bus_size,
    output logic [BUS_DATA_W-1:0] bus_wdata,
    input  logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic                  bus_ack,
    output logic                  irq_done,
    output logic                  irq_half
);
    logic              ld_src, ld_dst, ld_cnt, ld_size, start, clr_flags;
    logic              busy, done, half;
    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic [CNT_W-1:0]  cur_cnt;
    logic [1:0]        cur_size;

    cs_dma_regport #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regport (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .cur_cnt   (cur_cnt),
        .cur_size  (cur_size),
        .cur_done  (done),
        .cur_half  (half),
        .ld_src    (ld_src),
        .ld_dst    (ld_dst),
        .ld_cnt    (ld_cnt),
        .ld_size   (ld_size),
        .start     (start),
        .clr_flags (clr_flags),
        .reg_rdata (reg_rdata)
    );

    cs_dma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_src    (ld_src),
        .ld_dst    (ld_dst),
        .ld_cnt    (ld_cnt),
        .ld_size   (ld_size),
        .start     (start),
        .clr_flags (clr_flags),
        .wr_data   (reg_wdata),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .src_o     (cur_src),
        .dst_o     (cur_dst),
        .cnt_o     (cur_cnt),
        .size_o    (cur_size),
        .busy      (busy),
        .done      (done),
        .half      (half),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata)
    );

    assign irq_done = done;
    assign irq_half = half;
endmodule

// File: rtl/cs_dma_engine_chk.sv
module cs_dma_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_cmd,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_done
);
    AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd |-> bus_gnt); // R6

    AST_YIELD_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd && bus_we && bus_ack) |=> !bus_req); // R5

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd && !bus_we && bus_ack) |=> (bus_cmd && bus_we)); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd && !bus_ack) |=> (bus_cmd && $stable(bus_addr) && $stable(bus_we))); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !bus_req); // R7
endmodule

bind cs_dma_engine cs_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_cmd  (bus_cmd),
    .bus_we   (bus_we),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .irq_done (irq_done)
);

// File: tb/cs_dma_engine_bench.sv
`timescale 1ns/1ps
module cs_dma_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         bus_req, bus_cmd, bus_we, irq_done, irq_half;
    logic         bus_gnt = 1'b0;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_size;
    logic [127:0] bus_wdata, bus_rdata;

    int errors = 0;
    int checks = 0;
    int gnt_lat = 0;
    int wait_cnt = 0;
    int nwr = 0;
    int half_at = 0;
    bit half_seen = 0;
    bit rel_pend = 0;
    bit finished = 0;

    logic [7:0] mem [0:1023];

    typedef struct {
        logic [31:0]  s;
        logic [31:0]  d;
        logic [1:0]   sz;
        logic [127:0] data;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cs_dma_engine u_cs_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq_done(irq_done),
        .irq_half(irq_half)
    );

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd3) ? 16 : (1 << c);
    endfunction

    function automatic logic [127:0] bmask(input logic [1:0] c);
        return (c == 2'd3) ? '1 : ((128'd1 << (8 * nbytes(c))) - 128'd1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus-side models: arbiter and memory
    always @(posedge clk) begin
        if (!rst_n || !bus_req) begin
            bus_gnt  <= 1'b0;
            wait_cnt <= 0;
        end else if (!bus_gnt) begin
            if (wait_cnt >= gnt_lat) bus_gnt <= 1'b1;
            else wait_cnt <= wait_cnt + 1;
        end
        bus_ack <= rst_n && bus_cmd && !bus_ack;
        if (bus_cmd && bus_we && bus_ack)
            for (int i = 0; i < nbytes(bus_size); i++)
                mem[bus_addr[9:0] + 10'(i)] <= bus_wdata[8*i +: 8];
    end

    always @* begin
        bus_rdata = '0;
        if (bus_cmd && !bus_we && bus_ack)
            for (int i = 0; i < nbytes(bus_size); i++)
                bus_rdata[8*i +: 8] = mem[bus_addr[9:0] + 10'(i)];
    end

    // monitor: compares observed units against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rel_pend) begin
                check(!bus_req, "R5 bus released after unit", 128'(bus_req), 128'd0);
                rel_pend = 0;
            end
            if (bus_cmd && bus_ack) begin
                if (sb.size() == 0) begin
                    check(0, "R3 unexpected bus access", 128'(bus_addr), 128'd0);
                end else if (!bus_we) begin
                    check(bus_addr == sb[0].s, "R4 read address", 128'(bus_addr), 128'(sb[0].s));
                    check(bus_size == sb[0].sz, "R3 read size", 128'(bus_size), 128'(sb[0].sz));
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check(bus_addr == it.d, "R4 write address", 128'(bus_addr), 128'(it.d));
                    check((bus_wdata & bmask(it.sz)) == it.data, "R3 write data",
                          bus_wdata & bmask(it.sz), it.data);
                    nwr++;
                    rel_pend = 1;
                end
            end
            if (irq_half && !half_seen && half_at != 0) begin
                half_seen = 1;
                check(nwr == half_at, "R8 half point", 128'(nwr), 128'(half_at));
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !irq_done; i++) @(negedge clk);
    endtask

    task automatic run_block(input logic [31:0] s, input logic [31:0] d, input int n,
                             input logic [1:0] sz, input int lat, input bit tamper);
        logic [31:0] v;
        int ub;
        ub = nbytes(sz);
        gnt_lat = lat;
        wr_reg(2'd0, s);
        wr_reg(2'd1, d);
        wr_reg(2'd2, 32'(n));
        rd_reg(2'd0, v);
        check(v == s, "R2 source readback", 128'(v), 128'(s));
        rd_reg(2'd2, v);
        check(v == 32'(n), "R2 count readback", 128'(v), 128'(n));
        for (int k = 0; k < n; k++) begin
            exp_t it;
            it.s = s + 32'(k * ub);
            it.d = d + 32'(k * ub);
            it.sz = sz;
            it.data = '0;
            for (int b = 0; b < ub; b++) it.data[8*b +: 8] = mem[it.s[9:0] + 10'(b)];
            sb.push_back(it);
        end
        nwr = 0;
        half_seen = 0;
        half_at = n - n / 2;
        wr_reg(2'd3, {27'd0, 1'b0, 1'b0, sz, 1'b1});
        #1 check(bus_req == 1'b1, "R12 auto request after enable", 128'(bus_req), 128'd1);
        if (tamper) begin
            wr_reg(2'd2, 32'd1);
            wr_reg(2'd0, 32'h0);
            wr_reg(2'd1, 32'h0);
            wr_reg(2'd3, {27'd0, 1'b0, 1'b0, 2'd3, 1'b1});
        end
        wait_done();
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R11 all units moved", 128'(sb.size()), 128'd0);
        check(nwr == n, "R7 unit count", 128'(nwr), 128'(n));
        rd_reg(2'd0, v);
        check(v == s + 32'(n * ub), "R4 final source", 128'(v), 128'(s + 32'(n * ub)));
        rd_reg(2'd1, v);
        check(v == d + 32'(n * ub), "R4 final destination", 128'(v), 128'(d + 32'(n * ub)));
        rd_reg(2'd2, v);
        check(v == 32'd0, "R4 final count", 128'(v), 128'd0);
        rd_reg(2'd3, v);
        check(v == {27'd0, 1'b1, 1'b1, sz, 1'b0}, "R7 control after done", 128'(v),
              128'({27'd0, 1'b1, 1'b1, sz, 1'b0}));
        check(irq_done && irq_half, "R8 irq lines", 128'({irq_done, irq_half}), 128'd3);
        wr_reg(2'd3, 32'h8);
        rd_reg(2'd3, v);
        check(v[4:3] == 2'b00, "R9 flags cleared", 128'(v[4:3]), 128'd0);
        check(!irq_done && !irq_half, "R9 irq lines cleared", 128'({irq_done, irq_half}), 128'd0);
    endtask

    initial begin
        logic [31:0] v;
        bit seen_req;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !bus_cmd && !irq_done && !irq_half, "R1 outputs after reset",
              128'({bus_req, bus_cmd, irq_done, irq_half}), 128'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            check(v == 32'd0, "R1 register reset value", 128'(v), 128'd0);
        end

        run_block(32'h100, 32'h200, 8, 2'd2, 0, 0);
        run_block(32'h040, 32'h300, 5, 2'd0, 3, 1);
        run_block(32'h080, 32'h340, 6, 2'd1, 1, 0);
        run_block(32'h010, 32'h380, 3, 2'd3, 2, 0);

        // R10: zero count completes at once with no bus activity
        wr_reg(2'd2, 32'd0);
        half_at = 0;
        seen_req = 0;
        wr_reg(2'd3, 32'h1);
        check(irq_done == 1'b1, "R10 done on zero count", 128'(irq_done), 128'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_req) seen_req = 1;
        end
        check(!seen_req, "R10 no bus request", 128'(seen_req), 128'd0);
        rd_reg(2'd3, v);
        check(v[0] == 1'b0 && v[3] == 1'b1, "R10 control state", 128'(v), 128'h8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule